// File: doc/BRIEF.md
# Root Port Error and PME Control

This block implements the control logic behind the 16-bit root control register of a PCI Express root port. Configuration software writes the register through a simple write strobe with two byte enables, and the current value can be read back at all times. The register holds one enable for the power-management-event (PME) interrupt and three enables that turn error events of a given severity into a system error (SERR) request.

Received PME messages set a sticky PME status flag, and a dedicated write-one-to-clear input clears it. The PME interrupt is a level output. It is high while status is set and the interrupt enable is set. So setting the enable while status is already pending raises the interrupt at once, and clearing the enable withdraws it. Error events arrive as single-cycle pulses, one per severity. They come on two vectors: one for errors reported by devices below the port and one for errors the port detects itself. Any pulse of an enabled severity produces a one-cycle SERR request. The three severity enables decide this on their own, so no other SERR enable elsewhere in the function can suppress it.

Top module: `rport_err_pme_ctl`

## Requirements
- R1: After reset, cfg_rdata reads 0000h and pme_sts, pme_irq and serr_req are all 0.
- R2: Bits 15:4 always read as zero. A write with cfg_be = 2'b10 (only the upper byte enabled) leaves the whole register unchanged.
- R3: A write with cfg_be[0] = 1 loads cfg_wdata[3:0] into register bits 3:0, visible on cfg_rdata the cycle after the write. Bit 3 is the PME interrupt enable, bit 2 the fatal-error enable, bit 1 the non-fatal uncorrectable enable, bit 0 the correctable enable.
- R4: A pme_msg pulse sets pme_sts the following cycle, whatever the state of bit 3. pme_irq is high in every cycle in which both pme_sts and bit 3 are 1.
- R5: When bit 3 is written from 0 to 1 while pme_sts is already 1, pme_irq rises the cycle after the write.
- R6: When bit 3 is written from 1 to 0 while pme_irq is high, pme_irq falls the cycle after the write and pme_sts stays 1.
- R7: A pme_sts_clr pulse clears pme_sts, and with it pme_irq, the following cycle. If pme_msg arrives in the same cycle, the message wins and pme_sts stays 1.
- R8: A pulse on err_dn[i] or err_loc[i] whose severity enable is 1 gives serr_req = 1 for exactly the next cycle, for index 0 correctable, 1 non-fatal and 2 fatal. No enable other than register bits 2:0 gates this.
- R9: Error pulses whose severity enable is 0 never raise serr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 2 | Byte enables of the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Current register value |
| pme_msg | input | 1 | A PME message was received |
| pme_sts_clr | input | 1 | Write-one-to-clear for PME status |
| err_dn | input | 3 | Error pulses reported from below, by severity |
| err_loc | input | 3 | Error pulses detected locally, by severity |
| pme_sts | output | 1 | PME status flag |
| pme_irq | output | 1 | Level PME interrupt |
| serr_req | output | 1 | One-cycle system error request |

## Verification
All state in this block reaches a port within one cycle. The enables appear on cfg_rdata right after a write. A wrong status flag shows on pme_sts the cycle after the message or clear. A bad enable/status combination shows on pme_irq in the same cycle the state is wrong. A wrong severity mask or a missing pulse shortening shows on serr_req the cycle after the error pulse, or as a second high cycle after it. The directed scenarios therefore sample one cycle after each stimulus and again one cycle later.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  localparam int REG_W    = 16;
  localparam int BE_W     = REG_W / 8;
  localparam int SEV_N    = 3;
  localparam int CTL_BITS = SEV_N + 1;

  // Severity indices shared by the error vectors and the enable field.
  localparam int SEV_CORR     = 0;
  localparam int SEV_NONFATAL = 1;
  localparam int SEV_FATAL    = 2;

  typedef struct packed {
    logic             pme_ie;
    logic [SEV_N-1:0] sev_en;
  } ctl_t;

  // Byte-enable merge: only the low byte carries writable bits.
  function automatic ctl_t ctl_merge(input ctl_t cur,
                                     input logic [REG_W-1:0] wd,
                                     input logic [BE_W-1:0] be);
    ctl_t nxt;
    nxt = cur;
    if (be[0]) nxt = ctl_t'(wd[CTL_BITS-1:0]);
    return nxt;
  endfunction

  function automatic logic [REG_W-1:0] ctl_view(input ctl_t c);
    return {{(REG_W-CTL_BITS){1'b0}}, c};
  endfunction

  function automatic logic sev_fire(input logic en, input logic dn, input logic loc);
    return en & (dn | loc);
  endfunction

  // Status update: a new message takes precedence over a clear.
  function automatic logic sts_next(input logic cur, input logic msg, input logic clr);
    return msg | (cur & ~clr);
  endfunction

endpackage

// File: rtl/rpc_cfg_regs.sv
module rpc_cfg_regs
  import rpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [BE_W-1:0]  be,
  input  logic [REG_W-1:0] wdata,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata,
  output logic             ie_rise,
  output logic             ie_fall
);

  ctl_t ctl_q;
  ctl_t ctl_d;
  logic unused_hi;

  assign ctl_d = wr ? ctl_merge(ctl_q, wdata, be) : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ie_rise   = ~ctl_q.pme_ie &  ctl_d.pme_ie;
  assign ie_fall   =  ctl_q.pme_ie & ~ctl_d.pme_ie;
  assign ctl       = ctl_q;
  assign rdata     = ctl_view(ctl_q);
  assign unused_hi = ^{wdata[REG_W-1:CTL_BITS], be[BE_W-1:1]};

endmodule

// File: rtl/rpc_pme_tracker.sv
module rpc_pme_tracker
  import rpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic msg,
  input  logic clr,
  input  logic ie,
  output logic sts,
  output logic irq
);

  logic sts_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= sts_next(sts_q, msg, clr);
  end

  assign sts = sts_q;
  // Level interrupt: follows the enable in both directions.
  assign irq = sts_q & ie;

endmodule

// File: rtl/rpc_serr_gate.sv
module rpc_serr_gate
  import rpc_pkg::*;
#(
  parameter int N = SEV_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] dn,
  input  logic [N-1:0] loc,
  output logic [N-1:0] hits,
  output logic         serr
);

  logic serr_q;

  for (genvar i = 0; i < N; i++) begin : g_sev
    assign hits[i] = sev_fire(en[i], dn[i], loc[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= |hits;
  end

  assign serr = serr_q;

endmodule

// File: rtl/rport_err_pme_ctl.sv
module rport_err_pme_ctl
  import rpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [BE_W-1:0]  cfg_be,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             pme_msg,
  input  logic             pme_sts_clr,
  input  logic [SEV_N-1:0] err_dn,
  input  logic [SEV_N-1:0] err_loc,
  output logic             pme_sts,
  output logic             pme_irq,
  output logic             serr_req
);

  ctl_t             ctl;
  logic             ie_rise;
  logic             ie_fall;
  logic [SEV_N-1:0] sev_hits;

  rpc_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .ctl     (ctl),
    .rdata   (cfg_rdata),
    .ie_rise (ie_rise),
    .ie_fall (ie_fall)
  );

  rpc_pme_tracker u_pme (
    .clk   (clk),
    .rst_n (rst_n),
    .msg   (pme_msg),
    .clr   (pme_sts_clr),
    .ie    (ctl.pme_ie),
    .sts   (pme_sts),
    .irq   (pme_irq)
  );

  rpc_serr_gate #(.N(SEV_N)) u_serr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl.sev_en),
    .dn    (err_dn),
    .loc   (err_loc),
    .hits  (sev_hits),
    .serr  (serr_req)
  );

endmodule

// File: rtl/rpc_checker.sv
module rpc_checker
  import rpc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic [BE_W-1:0]  cfg_be,
  input logic [REG_W-1:0] cfg_wdata,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             pme_msg,
  input logic             pme_sts_clr,
  input logic [SEV_N-1:0] err_dn,
  input logic [SEV_N-1:0] err_loc,
  input logic             pme_sts,
  input logic             pme_irq,
  input logic             serr_req,
  input logic             ie_rise,
  input logic             ie_fall,
  input logic [SEV_N-1:0] sev_hits
);

  logic [SEV_N-1:0] en_view;
  assign en_view = cfg_rdata[SEV_N-1:0];

  p_upper_byte_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 2'b10) |=> $stable(cfg_rdata));

  p_low_byte_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be[0]) |=> (cfg_rdata[CTL_BITS-1:0] == $past(cfg_wdata[CTL_BITS-1:0])));

  p_msg_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pme_msg |=> pme_sts);

  p_irq_on_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_rise && pme_sts && !pme_sts_clr) |=> pme_irq);

  p_irq_withdrawn_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_fall && pme_sts && !pme_sts_clr) |=> (!pme_irq && pme_sts));

  p_status_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_sts_clr && !pme_msg) |=> (!pme_sts && !pme_irq));

  p_serr_on_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|((err_dn | err_loc) & en_view)) |=> serr_req);

  p_serr_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|((err_dn | err_loc) & en_view))) |=> !serr_req);

  p_hits_within_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((sev_hits & ~en_view) == '0));

endmodule

bind rport_err_pme_ctl rpc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_be      (cfg_be),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .pme_msg     (pme_msg),
  .pme_sts_clr (pme_sts_clr),
  .err_dn      (err_dn),
  .err_loc     (err_loc),
  .pme_sts     (pme_sts),
  .pme_irq     (pme_irq),
  .serr_req    (serr_req),
  .ie_rise     (ie_rise),
  .ie_fall     (ie_fall),
  .sev_hits    (sev_hits)
);

// File: tb/rport_err_pme_ctl_test.sv
module rport_err_pme_ctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_be = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        pme_msg = 1'b0;
  logic        pme_sts_clr = 1'b0;
  logic [2:0]  err_dn = '0;
  logic [2:0]  err_loc = '0;
  logic        pme_sts;
  logic        pme_irq;
  logic        serr_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rport_err_pme_ctl uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pme_msg(pme_msg),
    .pme_sts_clr(pme_sts_clr), .err_dn(err_dn), .err_loc(err_loc),
    .pme_sts(pme_sts), .pme_irq(pme_irq), .serr_req(serr_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] be, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    step();
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic pulse_pme(input logic msg, input logic clr);
    pme_msg = msg; pme_sts_clr = clr;
    step();
    pme_msg = 1'b0; pme_sts_clr = 1'b0;
  endtask

  task automatic pulse_err(input logic [2:0] dn, input logic [2:0] loc);
    err_dn = dn; err_loc = loc;
    step();
    err_dn = '0; err_loc = '0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", cfg_rdata, 16'h0000);
    chk("R1 pme_sts", {15'b0, pme_sts}, 16'h0);
    chk("R1 pme_irq", {15'b0, pme_irq}, 16'h0);
    chk("R1 serr_req", {15'b0, serr_req}, 16'h0);
  endtask

  task automatic t_register();
    cfg_write(2'b01, 16'hFFFF);
    chk("R2/R3 all-ones write", cfg_rdata, 16'h000F);
    cfg_write(2'b10, 16'h0000);
    chk("R2 upper byte write ignored", cfg_rdata, 16'h000F);
    cfg_write(2'b11, 16'hA5A5);
    chk("R2/R3 both bytes", cfg_rdata, 16'h0005);
    cfg_write(2'b00, 16'h000A);
    chk("R3 no byte enable", cfg_rdata, 16'h0005);
    cfg_write(2'b01, 16'h0000);
    chk("R3 cleared", cfg_rdata, 16'h0000);
  endtask

  task automatic t_pme_late_enable();
    pulse_pme(1'b1, 1'b0);
    chk("R4 status set while disabled", {15'b0, pme_sts}, 16'h1);
    chk("R4 no irq while disabled", {15'b0, pme_irq}, 16'h0);
    cfg_write(2'b01, 16'h0008);
    chk("R5 irq on enable with status pending", {15'b0, pme_irq}, 16'h1);
    cfg_write(2'b01, 16'h0000);
    chk("R6 irq withdrawn", {15'b0, pme_irq}, 16'h0);
    chk("R6 status kept", {15'b0, pme_sts}, 16'h1);
    pulse_pme(1'b0, 1'b1);
    chk("R7 status cleared", {15'b0, pme_sts}, 16'h0);
  endtask

  task automatic t_pme_enabled();
    cfg_write(2'b01, 16'h0008);
    chk("R4 irq quiet without status", {15'b0, pme_irq}, 16'h0);
    pulse_pme(1'b1, 1'b0);
    chk("R4 irq on message", {14'b0, pme_sts, pme_irq}, 16'h3);
    pulse_pme(1'b0, 1'b1);
    chk("R7 clear drops irq", {14'b0, pme_sts, pme_irq}, 16'h0);
    pulse_pme(1'b1, 1'b1);
    chk("R7 message beats clear", {14'b0, pme_sts, pme_irq}, 16'h3);
    pulse_pme(1'b0, 1'b1);
    cfg_write(2'b01, 16'h0000);
    chk("R7 cleanup", {14'b0, pme_sts, pme_irq}, 16'h0);
  endtask

  task automatic t_serr();
    for (int i = 0; i < 3; i++) begin
      logic [2:0] m;
      m = 3'b001 << i;
      cfg_write(2'b01, {13'b0, m});
      pulse_err(m, 3'b000);
      chk($sformatf("R8 downstream sev %0d", i), {15'b0, serr_req}, 16'h1);
      step();
      chk($sformatf("R8 single cycle sev %0d", i), {15'b0, serr_req}, 16'h0);
      pulse_err(3'b000, m);
      chk($sformatf("R8 local sev %0d", i), {15'b0, serr_req}, 16'h1);
      pulse_err(~m, ~m);
      chk($sformatf("R9 other severities sev %0d", i), {15'b0, serr_req}, 16'h0);
    end
    cfg_write(2'b01, 16'h0008);
    pulse_err(3'b111, 3'b111);
    chk("R9 all disabled", {15'b0, serr_req}, 16'h0);
    cfg_write(2'b01, 16'h0007);
    pulse_err(3'b100, 3'b000);
    chk("R8 all enabled", {15'b0, serr_req}, 16'h1);
    cfg_write(2'b01, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_register();
    t_pme_late_enable();
    t_pme_enabled();
    t_serr();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule